// File: doc/BRIEF.md
# Spectrum Band Sequencer with Peak Capture

This block drives a bank of spectrum-analyser bands. It visits eight frequency bands in a fixed cycle, from the lowest band (index 0) to the highest (index 7). It puts the current band index on a select output. Downstream logic uses that index to choose the switched-capacitor filter clock and the equalization gain for the band. The band centres double from one band to the next, from roughly 113 Hz up to roughly 14.5 kHz, and all bands share a Q near 1.414.

Each band has two intervals. The first is a settling interval, so the filter can recover from the switch. The second is a sampling interval. During the sampling interval the block watches signed converter samples and keeps the largest magnitude it sees. Both intervals are counted in ticks of a periodic enable, nominally 40 kHz. Both come from per-band parameter tables, and lower bands get longer intervals.

Samples arrive with a valid strobe, nominally at 31.25 kHz. Only the peak magnitude is needed, so a sample rate below the band frequencies is acceptable. When a band's sampling interval ends, the block reports the band index and its peak magnitude with a one-cycle strobe. It then moves on to the next band.

Top module: `spectrum_band_seq`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, puts the block into the following state: `band_sel` = 0, `sampling` = 0 (settling), `peak_valid` = 0, `peak_band` = 0 and `peak_mag` = 0.
- R2: Bands are visited in the order 0, 1, …, NUM_BANDS-1. After the last band the sequence wraps to band 0. `band_sel` changes only on the edge that ends a sampling interval.
- R3: The settling interval of band b lasts exactly SETTLE_TICKS[b] ticks. A tick is a cycle with `tick_en` high. Cycles without a tick never advance the schedule. Table entry b sits in bits [b*CNT_W +: CNT_W], and every entry must be at least 1.
- R4: `sampling` is high exactly during the sampling interval of the current band. That interval begins on the edge after the last settling tick and lasts SAMPLE_TICKS[b] ticks.
- R5: On the edge after the last sampling tick, `peak_valid` goes high for exactly one cycle. In that cycle `peak_band` holds the band that just finished. `peak_band` and `peak_mag` keep their values until the next report.
- R6: The reported `peak_mag` is the largest magnitude of all samples taken during the window. A sample is taken when `smp_valid` is high in a cycle where `sampling` is high. This includes the cycle of the final tick. If no sample was taken, the reported value is 0.
- R7: A sample presented while settling, or with `smp_valid` low, has no effect on any report.
- R8: Magnitude is |x| for a two's-complement sample x. The most negative code, -2^(SAMPLE_W-1), reports as 2^(SAMPLE_W-1)-1.
- R9: The peak clears at the start of each sampling window, so no value carries over from one band, or one round, to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Scheduling time-base enable, one cycle per tick |
| smp_valid | input | 1 | Converter sample strobe |
| smp_data | input | SAMPLE_W | Signed converter sample |
| band_sel | output | BAND_W | Current band index (filter clock / gain select) |
| sampling | output | 1 | High while the current band's sampling window is open |
| peak_valid | output | 1 | One-cycle strobe at the end of each window |
| peak_band | output | BAND_W | Band index of the last report |
| peak_mag | output | SAMPLE_W-1 | Peak magnitude of the last report |

## Verification
The bench runs a 4-bit sample width with small, unequal tick tables. This lets each window length and each code be covered many times. One pattern ticks every cycle and sweeps all sixteen codes, which separates correct sign and saturation handling from a plain bit truncation. A sparse pattern, with ticks every third cycle and samples every other cycle, shows that non-tick cycles hold the schedule and that gaps in the sample strobe are handled. Two further patterns isolate gating and clearing. One places large samples only in settling intervals. The other places no samples in the windows at all. Together they tell a leaking gate from a stale peak register. A reset in the middle of a window then shows that the sequence restarts at band 0.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {
    PH_SETTLE = 1'b0,
    PH_SAMPLE = 1'b1
  } phase_e;
endpackage

// File: rtl/sbs_phase_timer.sv
// Counts ticks within one phase; done pulses on the tick that ends it.
module sbs_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = tick_en && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || done) cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sbs_peak_hold.sv
// Saturating magnitude and running maximum for one sampling window.
module sbs_peak_hold #(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       take,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-2:0]        peak_q,
  output logic [SAMPLE_W-2:0]        peak_d
);
  localparam int MAG_W = SAMPLE_W - 1;

  function automatic logic [MAG_W-1:0] sat_mag(input logic signed [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] flipped;
    if (s == {1'b1, {(SAMPLE_W-1){1'b0}}}) return {MAG_W{1'b1}};
    flipped = SAMPLE_W'(-s);
    return s[SAMPLE_W-1] ? flipped[MAG_W-1:0] : s[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] mag;

  always_comb begin
    mag    = sat_mag(sample);
    peak_d = (take && (mag > peak_q)) ? mag : peak_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) peak_q <= '0;
    else              peak_q <= peak_d;
  end
endmodule

// File: rtl/spectrum_band_seq.sv
module spectrum_band_seq #(
  parameter int NUM_BANDS = 8,
  parameter int SAMPLE_W  = 12,
  parameter int CNT_W     = 16,
  // entry b at [b*CNT_W +: CNT_W]; band 0 (lowest) is the rightmost entry
  parameter logic [NUM_BANDS*CNT_W-1:0] SETTLE_TICKS = {
    16'd12, 16'd25, 16'd50, 16'd100, 16'd200, 16'd400, 16'd800, 16'd1600},
  parameter logic [NUM_BANDS*CNT_W-1:0] SAMPLE_TICKS = {
    16'd25, 16'd50, 16'd100, 16'd200, 16'd400, 16'd800, 16'd1600, 16'd3200},
  localparam int BAND_W = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_en,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  output logic [BAND_W-1:0]          band_sel,
  output logic                       sampling,
  output logic                       peak_valid,
  output logic [BAND_W-1:0]          peak_band,
  output logic [SAMPLE_W-2:0]        peak_mag
);
  import sbs_pkg::*;

  localparam int MAG_W = SAMPLE_W - 1;
  localparam logic [BAND_W-1:0] LAST_BAND = BAND_W'(NUM_BANDS - 1);

  logic [CNT_W-1:0] settle_len [NUM_BANDS];
  logic [CNT_W-1:0] sample_len [NUM_BANDS];

  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_tbl
    assign settle_len[g] = SETTLE_TICKS[g*CNT_W +: CNT_W];
    assign sample_len[g] = SAMPLE_TICKS[g*CNT_W +: CNT_W];
  end

  phase_e           phase_q;
  logic [BAND_W-1:0] band_q;
  logic [CNT_W-1:0] phase_limit;
  logic             phase_done;
  logic             win_open;   // settling ends, window opens
  logic             win_close;  // window ends, report issues
  logic             take;
  logic [MAG_W-1:0] peak_q;
  logic [MAG_W-1:0] peak_d;

  function automatic logic [BAND_W-1:0] next_band(input logic [BAND_W-1:0] b);
    return (b == LAST_BAND) ? '0 : b + BAND_W'(1);
  endfunction

  assign phase_limit = (phase_q == PH_SAMPLE) ? sample_len[band_q] : settle_len[band_q];
  assign win_open    = phase_done && (phase_q == PH_SETTLE);
  assign win_close   = phase_done && (phase_q == PH_SAMPLE);
  assign take        = smp_valid && (phase_q == PH_SAMPLE);

  sbs_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .limit   (phase_limit),
    .done    (phase_done)
  );

  sbs_peak_hold #(.SAMPLE_W(SAMPLE_W)) peak_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (win_open),
    .take   (take),
    .sample (smp_data),
    .peak_q (peak_q),
    .peak_d (peak_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_SETTLE;
      band_q     <= '0;
      peak_valid <= 1'b0;
      peak_band  <= '0;
      peak_mag   <= '0;
    end else begin
      peak_valid <= win_close;
      if (win_open) phase_q <= PH_SAMPLE;
      if (win_close) begin
        phase_q   <= PH_SETTLE;
        band_q    <= next_band(band_q);
        peak_band <= band_q;
        peak_mag  <= peak_d;
      end
    end
  end

  assign band_sel = band_q;
  assign sampling = (phase_q == PH_SAMPLE);
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int NUM_BANDS = 8,
  parameter int BAND_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic [BAND_W-1:0] band_sel,
  input logic              sampling,
  input logic              peak_valid,
  input logic [BAND_W-1:0] peak_band,
  input logic              win_open,
  input logic              win_close
);
  localparam logic [BAND_W-1:0] LAST_BAND = BAND_W'(NUM_BANDS - 1);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (band_sel == '0 && !sampling && !peak_valid));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    peak_valid |=> !peak_valid);

  a_r5_close_gives_strobe: assert property (@(posedge clk) disable iff (rst)
    win_close |=> peak_valid);

  a_r5_strobe_needs_close: assert property (@(posedge clk) disable iff (rst)
    peak_valid |-> $past(win_close));

  a_r2_band_step: assert property (@(posedge clk) disable iff (rst)
    peak_valid |-> (band_sel == ((peak_band == LAST_BAND) ? '0 : peak_band + BAND_W'(1))));

  a_r2_band_moves_at_close: assert property (@(posedge clk) disable iff (rst)
    !$stable(band_sel) |-> peak_valid);

  a_r3_phase_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(sampling) |-> $past(tick_en));

  a_r4_open_enters_window: assert property (@(posedge clk) disable iff (rst)
    win_open |=> sampling);
endmodule

bind spectrum_band_seq sbs_checker #(
  .NUM_BANDS (NUM_BANDS),
  .BAND_W    (BAND_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick_en    (tick_en),
  .band_sel   (band_sel),
  .sampling   (sampling),
  .peak_valid (peak_valid),
  .peak_band  (peak_band),
  .win_open   (win_open),
  .win_close  (win_close)
);

// File: tb/spectrum_band_seq_tb.sv
module spectrum_band_seq_tb_top;
  localparam int NB = 8;
  localparam int SW = 4;
  localparam int CW = 4;
  localparam int BW = 3;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 tick_en = 1'b0;
  logic                 smp_valid = 1'b0;
  logic signed [SW-1:0] smp_data = '0;
  logic [BW-1:0]        band_sel;
  logic                 sampling;
  logic                 peak_valid;
  logic [BW-1:0]        peak_band;
  logic [SW-2:0]        peak_mag;

  // settle: band b -> 4 - b/2 ticks; sample: band b -> 8 - b ticks
  spectrum_band_seq #(
    .NUM_BANDS    (NB),
    .SAMPLE_W     (SW),
    .CNT_W        (CW),
    .SETTLE_TICKS ({4'd1, 4'd1, 4'd2, 4'd2, 4'd3, 4'd3, 4'd4, 4'd4}),
    .SAMPLE_TICKS ({4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8})
  ) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .smp_valid(smp_valid), .smp_data(smp_data),
    .band_sel(band_sel), .sampling(sampling), .peak_valid(peak_valid),
    .peak_band(peak_band), .peak_mag(peak_mag)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int reports = 0;

  // reference state
  int m_band, m_cnt, m_peak;
  bit m_samp;
  int last_band, last_mag;

  function automatic int settle_of(input int b); return 4 - b / 2; endfunction
  function automatic int sample_of(input int b); return 8 - b; endfunction
  function automatic int mag_of(input int v);
    if (v == -(1 << (SW - 1))) return (1 << (SW - 1)) - 1;
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_band = 0; m_cnt = 0; m_peak = 0; m_samp = 0; last_band = 0; last_mag = 0;
  endtask

  // one cycle: drive at negedge, compare after the posedge
  task automatic cyc(input bit t, input bit v, input int d);
    bit exp_v;
    tick_en = t; smp_valid = v; smp_data = SW'(d);
    exp_v = 0;
    if (m_samp && v && mag_of(d) > m_peak) m_peak = mag_of(d);
    if (t) begin
      if (m_cnt == (m_samp ? sample_of(m_band) : settle_of(m_band)) - 1) begin
        m_cnt = 0;
        if (m_samp) begin
          exp_v = 1; last_band = m_band; last_mag = m_peak;
          m_band = (m_band + 1) % NB; m_samp = 0;
        end else begin
          m_samp = 1; m_peak = 0;
        end
      end else m_cnt++;
    end
    @(posedge clk); #2;
    check(int'(band_sel) == m_band, "R2 band_sel", int'(band_sel), m_band);
    check(sampling == m_samp, "R3/R4 sampling", int'(sampling), int'(m_samp));
    check(peak_valid == exp_v, "R5 peak_valid", int'(peak_valid), int'(exp_v));
    check(int'(peak_band) == last_band, "R5 peak_band", int'(peak_band), last_band);
    check(int'(peak_mag) == last_mag, "R6/R7/R8/R9 peak_mag", int'(peak_mag), last_mag);
    if (peak_valid) reports++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; tick_en = 0; smp_valid = 0;
    repeat (3) @(posedge clk);
    #2;
    check(band_sel == '0, "R1 band_sel", int'(band_sel), 0);
    check(!sampling, "R1 sampling", int'(sampling), 0);
    check(!peak_valid, "R1 peak_valid", int'(peak_valid), 0);
    check(peak_mag == '0, "R1 peak_mag", int'(peak_mag), 0);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // A: tick every cycle, every code in turn (R6, R8)
    for (int k = 0; k < 2 * 56; k++) cyc(1, 1, (k % 16) - 8);
    check(reports == 16, "R2 wrap report count", reports, 16);

    // B: sparse ticks and samples, negative-heavy incl. most negative (R3, R8)
    for (int k = 0; k < 3 * 56; k++) cyc(k % 3 == 0, k % 2 == 0, -((k * 5) % 9));

    // C: large samples only while settling, small in window (R7, R9)
    for (int k = 0; k < 2 * 56; k++) cyc(k % 2 == 1, 1, m_samp ? ((k % 3) - 1) : ((k % 2) ? 7 : -8));

    // D: window samples withheld, settling ones present (R6, R7)
    for (int k = 0; k < 56; k++) cyc(1, !m_samp, -8);

    // E: reset mid-window restarts at band 0 (R1, R2)
    for (int k = 0; k < 25; k++) cyc(1, 1, 5);
    do_reset();
    for (int k = 0; k < 60; k++) cyc(1, 1, (k * 7) % 16 - 8);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule